// File: doc/BRIEF.md
# Frame-synced stereo PCM transmitter

This block sends 16-bit stereo PCM audio as a bit-clock slave. An external codec drives both the bit clock and the frame sync. The block oversamples both signals in its own system clock domain. Each edge of the frame sync opens a channel slot, and in that slot one word is shifted out most significant bit first. The first bit is driven one bit clock after the edge. The output changes only after falling edges of the bit clock, so the codec can capture it on rising edges.

Sample words are read from memory through a request port. The addresses come from a pair of buffer descriptors. The active descriptor holds the address and word count in use. The standby descriptor is written by software and takes over automatically when the active one runs dry. A done flag, which can be masked onto an interrupt line, tells software that both descriptors are empty and a new buffer must be supplied. A start pulse arms the transmitter. A stop pulse halts it and discards all queued work.

Top module: `pcm_fs_tx`

## Requirements
- R1: Each word is 16 bits long and is sent most significant bit first. Exactly 16 data bits follow a slot start, and the output returns low after the last bit.
- R2: A rising or a falling edge on `fsync_i` starts a slot. The first data bit is driven after the first falling bit-clock edge that follows the falling bit-clock edge at which the frame-sync change was seen. This is a lead of one bit clock. `sdata_o` changes only after a detected falling bit-clock edge, or when the transmitter stops.
- R3: When no fetched word is waiting at the start of a slot, the slot carries all zeros. `sdata_o` is also low between words.
- R4: The read request port uses a valid/ready handshake. While `rd_valid_o` is high and `rd_ready_i` is low, the request and its address hold steady. `rd_data_i` is taken exactly one cycle after a request is accepted. Addresses rise by one per word from the descriptor address.
- R5: A pulse on `desc_wr_i` loads the standby descriptor. When the active count is zero and the standby count is nonzero, the standby address and count move into the active descriptor and the standby count clears. Words from the first buffer are therefore followed directly by words from the second.
- R6: `done_o` is high exactly when both the active and the standby counts are zero. No read request is issued while it is high. `irq_o` is `done_o` gated by `irq_en_i`.
- R7: A pulse on `tx_stop_i` halts transmission and clears both counts, any pending read and any fetched word. After that, `sdata_o` stays low, frame-sync edges are ignored and no read is requested until `tx_start_i` is pulsed. If both pulses arrive in the same cycle, stop wins.
- R8: After reset, `sdata_o` is low, `done_o` is high, `irq_o` is low when `irq_en_i` is low, and `rd_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Bit clock from the codec (never driven by the block) |
| fsync_i | input | 1 | Frame sync from the codec; level selects the channel |
| sdata_o | output | 1 | Serial data to the codec |
| tx_start_i | input | 1 | Pulse: arm the transmitter |
| tx_stop_i | input | 1 | Pulse: halt and clear all queued work |
| irq_en_i | input | 1 | Interrupt mask for the done flag |
| desc_wr_i | input | 1 | Pulse: load the standby descriptor |
| desc_addr_i | input | ADDR_W | Standby buffer start address (in words) |
| desc_cnt_i | input | CNT_W | Standby buffer length in words |
| done_o | output | 1 | Both descriptors empty |
| irq_o | output | 1 | Masked done interrupt |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Read request accepted when high with valid |
| rd_addr_o | output | ADDR_W | Read word address |
| rd_data_i | input | WORD_W | Read data, valid one cycle after acceptance |

## Verification
The assertions assume that each level of the bit clock lasts several system clock cycles, so the synchronisers see every edge. They also assume the frame sync changes together with a falling bit-clock edge, that at least 17 bit clocks pass between frame-sync edges, and that memory returns data exactly one cycle after acceptance. The stimulus holds each bit-clock level for six system clocks and toggles the frame sync at the first falling edge of every 20-bit-clock slot. A memory model answers on the following cycle. Descriptor writes and start or stop pulses are issued only between slots, and read back-pressure is applied in a pattern that always clears well inside one bit period.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  typedef enum logic [1:0] {EDGE_RISE, EDGE_FALL, EDGE_ANY} edge_sel_e;
  typedef enum logic [1:0] {SH_IDLE, SH_LEAD, SH_SHIFT} shift_st_e;
endpackage

// File: rtl/pcm_tx_sync.sv
module pcm_tx_sync
  import pcm_tx_pkg::*;
#(
  parameter int        STAGES = 2,
  parameter edge_sel_e SEL    = EDGE_ANY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic evt_o
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= pin_i;
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];

  if (SEL == EDGE_RISE) begin : g_rise
    assign evt_o = chain[STAGES-1] & ~last_q;
  end else if (SEL == EDGE_FALL) begin : g_fall
    assign evt_o = ~chain[STAGES-1] & last_q;
  end else begin : g_any
    assign evt_o = chain[STAGES-1] ^ last_q;
  end
endmodule

// File: rtl/pcm_tx_fetch.sv
module pcm_tx_fetch #(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          kill_i,
  input  logic          desc_wr_i,
  input  logic [AW-1:0] desc_addr_i,
  input  logic [CW-1:0] desc_cnt_i,
  input  logic          take_i,
  input  logic          rd_ready_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          rd_valid_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [DW-1:0] word_o,
  output logic          word_vld_o,
  output logic          done_o
);
  logic [AW-1:0] cur_addr, nxt_addr;
  logic [CW-1:0] cur_cnt, nxt_cnt;
  logic [DW-1:0] hold;
  logic          hold_vld, pend;
  logic          cur_empty, handover, accept;

  assign cur_empty  = (cur_cnt == '0);
  assign handover   = cur_empty && (nxt_cnt != '0);
  assign rd_valid_o = en_i && !cur_empty && !hold_vld && !pend;
  assign accept     = rd_valid_o && rd_ready_i;
  assign rd_addr_o  = cur_addr;
  assign word_o     = hold;
  assign word_vld_o = hold_vld;
  assign done_o     = cur_empty && (nxt_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
      nxt_addr <= '0;
      nxt_cnt  <= '0;
      hold     <= '0;
      hold_vld <= 1'b0;
      pend     <= 1'b0;
    end else if (kill_i) begin
      cur_cnt  <= '0;
      nxt_cnt  <= '0;
      hold_vld <= 1'b0;
      pend     <= 1'b0;
    end else begin
      if (accept) begin
        cur_addr <= cur_addr + AW'(1);
        cur_cnt  <= cur_cnt - CW'(1);
      end else if (handover) begin
        cur_addr <= nxt_addr;
        cur_cnt  <= nxt_cnt;
      end
      if (desc_wr_i) begin
        nxt_addr <= desc_addr_i;
        nxt_cnt  <= desc_cnt_i;
      end else if (handover) begin
        nxt_cnt <= '0;
      end
      pend <= accept;
      if (pend) begin
        hold     <= rd_data_i;
        hold_vld <= 1'b1;
      end else if (take_i) begin
        hold_vld <= 1'b0;
      end
    end
  end

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i && !kill_i) |=> (rd_valid_o && $stable(rd_addr_o)));

  assert_rsp_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !kill_i) |=> ##1 (word_vld_o || $past(kill_i)));

  assert_handover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (handover && !kill_i) |=> (cur_cnt == $past(nxt_cnt)));

  assert_nxt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (handover && !kill_i && !desc_wr_i) |=> (nxt_cnt == '0));

  assert_empty_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rd_valid_o);

  assert_take_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> hold_vld);

  assert_kill_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> (done_o && !word_vld_o && !pend));
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift
  import pcm_tx_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          kill_i,
  input  logic          bclk_fall_i,
  input  logic          fs_edge_i,
  input  logic [DW-1:0] word_i,
  input  logic          word_vld_i,
  output logic          take_o,
  output logic          sdata_o
);
  localparam int CNTW = $clog2(DW);

  shift_st_e       st;
  logic            arm;
  logic [CNTW-1:0] cnt;
  logic [DW-2:0]   rest;
  logic            sd;
  logic            live, start_seen;

  assign live       = en_i && !kill_i;
  assign start_seen = arm || fs_edge_i;
  assign take_o     = live && bclk_fall_i && (st == SH_LEAD) && word_vld_i;
  assign sdata_o    = sd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SH_IDLE;
      arm  <= 1'b0;
      cnt  <= '0;
      rest <= '0;
      sd   <= 1'b0;
    end else if (!live) begin
      st   <= SH_IDLE;
      arm  <= 1'b0;
      cnt  <= '0;
      rest <= '0;
      sd   <= 1'b0;
    end else if (bclk_fall_i) begin
      arm <= 1'b0;
      case (st)
        SH_LEAD: begin
          sd   <= word_vld_i & word_i[DW-1];
          rest <= word_vld_i ? word_i[DW-2:0] : '0;
          cnt  <= CNTW'(DW-1);
          st   <= SH_SHIFT;
        end
        SH_SHIFT: begin
          if (cnt != '0) begin
            sd   <= rest[DW-2];
            rest <= {rest[DW-3:0], 1'b0};
            cnt  <= cnt - CNTW'(1);
          end else begin
            sd <= 1'b0;
            st <= SH_IDLE;
          end
        end
        default: sd <= 1'b0;
      endcase
      if (start_seen) st <= SH_LEAD;
    end else if (fs_edge_i) begin
      arm <= 1'b1;
    end
  end

  assert_change_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_o != $past(sdata_o)) |-> ($past(bclk_fall_i) || $past(!live)));

  assert_lead_after_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && bclk_fall_i && start_seen) |=> (st == SH_LEAD));

  assert_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SH_IDLE) |-> !sdata_o);

  assert_word_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (live && bclk_fall_i && (st == SH_SHIFT) && (cnt == '0) && !start_seen)
      |=> ((st == SH_IDLE) && !sdata_o));

  assert_stopped_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !sdata_o);
endmodule

// File: rtl/pcm_fs_tx.sv
module pcm_fs_tx
  import pcm_tx_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 8,
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              fsync_i,
  output logic              sdata_o,
  input  logic              tx_start_i,
  input  logic              tx_stop_i,
  input  logic              irq_en_i,
  input  logic              desc_wr_i,
  input  logic [ADDR_W-1:0] desc_addr_i,
  input  logic [CNT_W-1:0]  desc_cnt_i,
  output logic              done_o,
  output logic              irq_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i
);
  logic              en_q;
  logic              bclk_fall, fs_edge;
  logic              take;
  logic [WORD_W-1:0] word;
  logic              word_vld;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          en_q <= 1'b0;
    else if (tx_stop_i)  en_q <= 1'b0;
    else if (tx_start_i) en_q <= 1'b1;

  pcm_tx_sync #(.STAGES(SYNC_STAGES), .SEL(EDGE_FALL)) u_bclk_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(bclk_i), .evt_o(bclk_fall));

  pcm_tx_sync #(.STAGES(SYNC_STAGES), .SEL(EDGE_ANY)) u_fs_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(fsync_i), .evt_o(fs_edge));

  pcm_tx_fetch #(.AW(ADDR_W), .CW(CNT_W), .DW(WORD_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .en_i(en_q), .kill_i(tx_stop_i),
    .desc_wr_i(desc_wr_i), .desc_addr_i(desc_addr_i), .desc_cnt_i(desc_cnt_i),
    .take_i(take), .rd_ready_i(rd_ready_i), .rd_data_i(rd_data_i),
    .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o),
    .word_o(word), .word_vld_o(word_vld), .done_o(done_o));

  pcm_tx_shift #(.DW(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en_i(en_q), .kill_i(tx_stop_i),
    .bclk_fall_i(bclk_fall), .fs_edge_i(fs_edge),
    .word_i(word), .word_vld_i(word_vld),
    .take_o(take), .sdata_o(sdata_o));

  assign irq_o = done_o & irq_en_i;

  assert_start_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stop_i |=> (!rd_valid_o && !sdata_o));
endmodule

// File: tb/pcm_fs_tx_bench.sv
module pcm_fs_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b1;
  logic        fsync = 1'b0;
  logic        sdata;
  logic        tx_start = 1'b0, tx_stop = 1'b0, irq_en = 1'b0;
  logic        desc_wr = 1'b0;
  logic [15:0] desc_addr = '0;
  logic [7:0]  desc_cnt = '0;
  logic        done, irq, rd_valid;
  logic        rd_ready = 1'b1;
  logic [15:0] rd_addr;
  logic [15:0] rd_data = '0;

  int nchk = 0, nfail = 0;
  bit finished = 0;
  bit stall_mode = 0;
  int cyc = 0;
  int hold_bad = 0, stall_seen = 0;
  bit acc_prev = 0, stall_prev = 0;
  logic [15:0] addr_prev = '0;
  logic [15:0] exp_q[$];

  always #4 clk = ~clk;

  pcm_fs_tx u_pcm_fs_tx (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync), .sdata_o(sdata),
    .tx_start_i(tx_start), .tx_stop_i(tx_stop), .irq_en_i(irq_en),
    .desc_wr_i(desc_wr), .desc_addr_i(desc_addr), .desc_cnt_i(desc_cnt),
    .done_o(done), .irq_o(irq), .rd_valid_o(rd_valid), .rd_ready_i(rd_ready),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data));

  function automatic logic [15:0] mem_f(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  // Memory model: data one cycle after acceptance; hold check for R4.
  always @(negedge clk) begin
    if (acc_prev) rd_data = mem_f(addr_prev);
    if (stall_prev) begin
      stall_seen++;
      if (!rd_valid || rd_addr != addr_prev) hold_bad++;
    end
    cyc++;
    rd_ready = stall_mode ? (cyc % 5 == 0) : 1'b1;
    acc_prev   = rd_valid && rd_ready;
    stall_prev = rd_valid && !rd_ready;
    addr_prev  = rd_addr;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic push_desc(input logic [15:0] a, input logic [7:0] n);
    @(negedge clk);
    desc_addr = a; desc_cnt = n; desc_wr = 1'b1;
    @(negedge clk);
    desc_wr = 1'b0;
    for (int i = 0; i < n; i++) exp_q.push_back(mem_f(a + 16'(i)));
  endtask

  task automatic pulse_stop();
    @(negedge clk); tx_stop = 1'b1;
    @(negedge clk); tx_stop = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
  endtask

  // One slot = 20 bit clocks; frame sync toggles with the first falling edge.
  task automatic run_slots(input int n, input bit live, input string tag);
    for (int s = 0; s < n; s++) begin
      logic [19:0] got, expv;
      logic [15:0] w;
      w = (live && exp_q.size() > 0) ? exp_q.pop_front() : 16'h0000;
      got = '0;
      for (int b = 0; b < 20; b++) begin
        @(negedge clk);
        bclk = 1'b0;
        if (b == 0) fsync = ~fsync;
        tick(6);
        bclk = 1'b1;
        tick(3);
        got[b] = sdata;
        tick(2);
      end
      expv = '0;
      for (int k = 0; k < 16; k++) expv[k+1] = w[15-k];
      check(got == expv, tag, {12'h0, got}, {12'h0, expv});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: run hung actual=running expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(2);
    // R8 reset state
    check(sdata == 1'b0, "R8 sdata after reset", 32'(sdata), 0);
    check(done == 1'b1, "R8 done after reset", 32'(done), 1);
    check(irq == 1'b0, "R8 irq after reset", 32'(irq), 0);
    check(rd_valid == 1'b0, "R8 rd_valid after reset", 32'(rd_valid), 0);

    // R3: running with nothing to send gives all-zero slots; R6 irq when enabled
    irq_en = 1'b1;
    pulse_start();
    tick(4);
    run_slots(2, 1'b1, "R3 empty slots");
    check(irq == 1'b1, "R6 irq with done and enable", 32'(irq), 1);

    // R1 R2 R5: two buffers back to back through handover
    push_desc(16'h0100, 8'd3);
    push_desc(16'h0400, 8'd2);
    tick(10);
    check(done == 1'b0, "R6 done low with words queued", 32'(done), 0);
    check(irq == 1'b0, "R6 irq low with words queued", 32'(irq), 0);
    run_slots(6, 1'b1, "R1 R2 R5 handover stream");
    check(done == 1'b1, "R6 done after both buffers", 32'(done), 1);
    check(irq == 1'b1, "R6 irq after both buffers", 32'(irq), 1);

    // R6 mask
    irq_en = 1'b0;
    tick(2);
    check(irq == 1'b0, "R6 irq masked", 32'(irq), 0);

    // R4 back-pressure on the read port
    stall_mode = 1'b1;
    push_desc(16'h0800, 8'd4);
    run_slots(5, 1'b1, "R4 R1 stalled reads");
    stall_mode = 1'b0;
    tick(4);
    check(hold_bad == 0, "R4 request held while stalled", 32'(hold_bad), 0);
    check(stall_seen > 0, "R4 stalls exercised", 32'(stall_seen), 1);

    // R7 stop mid-stream
    push_desc(16'h1000, 8'd6);
    push_desc(16'h2000, 8'd3);
    run_slots(2, 1'b1, "R1 R2 before stop");
    pulse_stop();
    exp_q.delete();
    tick(2);
    check(done == 1'b1, "R7 both counts cleared", 32'(done), 1);
    check(sdata == 1'b0, "R7 sdata low after stop", 32'(sdata), 0);
    run_slots(2, 1'b0, "R7 frame sync ignored while stopped");
    check(rd_valid == 1'b0, "R7 no read while stopped", 32'(rd_valid), 0);
    pulse_start();
    tick(6);
    run_slots(1, 1'b1, "R7 R3 no stale word after restart");
    push_desc(16'h3000, 8'd2);
    run_slots(3, 1'b1, "R5 R1 fresh buffer after restart");
    check(done == 1'b1, "R6 done at end", 32'(done), 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule